// File: doc/BRIEF.md
# Comma-Aligning 10-bit Deserializer

This block turns a recovered serial bit stream into parallel 10-bit words. One bit arrives with each clock cycle in which `bit_en` is high, and everything runs in a single clock domain. The block keeps a history of the most recent bits and checks every one of the ten possible word phases against the two polarities of the 8b/10b comma. When a comma is found, the block moves the word boundary so that the word holding the comma is delivered with the comma starting at bit 0.

The `realign_en` input selects the alignment policy. When it is high, every comma pulls the boundary onto itself. When it is low, the block remembers whether alignment has ever been achieved since reset. If it has, the boundary stays frozen. If it has not, the first comma that arrives is aligned and all later commas are ignored. Downstream logic registers `word_out` on the `word_vld` strobe and uses `comma_flag` to spot aligned comma characters.

Top module: `comma_deser`

## Requirements
- R1: `word_out[0]` holds the earliest received bit of the word and `word_out[9]` holds the latest. Before any comma is seen, the first word consists of bits 0 to 9 received after reset.
- R2: `word_vld` is a single-cycle pulse. It comes one clock after every tenth accepted bit, so exactly 10 accepted bits separate consecutive pulses, and the first pulse follows the tenth bit after reset.
- R3: While reset is asserted, `word_out` is 0, `word_vld` is 0 and `comma_flag` is 0.
- R4: With `realign_en` = 1, a comma at any phase moves the boundary. The word that begins with the comma is output with the comma in bits 0 to 6, and later words keep the new boundary.
- R5: Both comma polarities are recognised. In received order these are 0011111 and 1100000. In the output word they appear as `word_out[6:0]` = 7'b1111100 and 7'b0000011 respectively.
- R6: `comma_flag` is updated together with `word_out` and held until the next word. It is 1 exactly when `word_out[6:0]` is one of the two commas, whatever the value of `realign_en`.
- R7: With `realign_en` = 0 and alignment already achieved, the boundary does not move. A comma that straddles the boundary is not aligned and yields `comma_flag` = 0. A comma that later falls on the boundary is still flagged.
- R8: With `realign_en` = 0 and no alignment since reset, the first comma received is aligned to the boundary and flagged. Only that first comma is aligned.
- R9: The alignment-achieved state is set by the first aligned comma and cleared only by reset. If alignment was achieved while `realign_en` = 1 and the input then drops to 0, the boundary freezes at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | Qualifies `bit_in` in this cycle |
| bit_in | input | 1 | Serial data bit |
| realign_en | input | 1 | 1: every comma realigns; 0: boundary set at most once |
| word_out | output | 10 | Parallel word, bit 0 received first |
| word_vld | output | 1 | One-cycle strobe for a new word |
| comma_flag | output | 1 | Current word holds a comma on the boundary |

## Verification
Two things can happen on the same word tick: the boundary can move, and the comma flag must be computed for the word that results. The flag therefore has to describe the word at the new boundary, not the one the old boundary would have produced. To provoke this, the bench places commas at every one of the ten bit offsets relative to the running boundary, in both polarities and under both policies, and inserts random idle gaps between bits. Each delivered word and its flag are compared with a bench model built from the full serialized stream. That model tracks the boundary and the alignment history on its own.

// File: rtl/comma_deser_pkg.sv
package comma_deser_pkg;
   localparam int unsigned DEF_WORD_W  = 10;
   localparam int unsigned DEF_COMMA_W = 7;
   // comma patterns, index = arrival order within the word
   localparam logic [6:0] DEF_PAT_P = 7'b1111100;
   localparam logic [6:0] DEF_PAT_N = 7'b0000011;
endpackage

// File: rtl/cd_shift.sv
module cd_shift #(
   parameter int unsigned W = 10,
   localparam int unsigned H = 2*W-1,
   localparam int unsigned CNTW = $clog2(W)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         bit_en,
   input  logic         bit_in,
   output logic [H-1:0] hist_nxt,
   output logic         tick
);
   logic [H-1:0]    hist_q;
   logic [CNTW-1:0] cnt_q;

   // newest bit enters at the top, oldest sits at index 0
   assign hist_nxt = bit_en ? {bit_in, hist_q[H-1:1]} : hist_q;
   assign tick     = bit_en && (cnt_q == CNTW'(W-1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hist_q <= '0;
         cnt_q  <= '0;
      end else if (bit_en) begin
         hist_q <= hist_nxt;
         cnt_q  <= tick ? '0 : cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/cd_match.sv
module cd_match #(
   parameter int unsigned W  = 10,
   parameter int unsigned CW = 7,
   parameter logic [CW-1:0] PAT_P = '0,
   parameter logic [CW-1:0] PAT_N = '0,
   localparam int unsigned HM = W+CW-1,
   localparam int unsigned DW = $clog2(W)
) (
   input  logic [HM-1:0] hist,
   output logic [W-1:0]  hit,
   output logic          any_hit,
   output logic [DW-1:0] first_d
);
   // delay d: window starts d bits earlier than the newest word
   for (genvar d = 0; d < W; d++) begin : g_phase
      localparam int unsigned LO = W-1-d;
      assign hit[d] = (hist[LO +: CW] == PAT_P) || (hist[LO +: CW] == PAT_N);
   end

   assign any_hit = |hit;

   // latest-arriving comma (smallest delay) wins
   always_comb begin
      first_d = '0;
      for (int i = W-1; i >= 0; i--) begin
         if (hit[i]) first_d = DW'(i);
      end
   end
endmodule

// File: rtl/cd_align.sv
module cd_align #(
   parameter int unsigned W = 10,
   localparam int unsigned DW = $clog2(W)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          realign_en,
   input  logic [W-1:0]  hit,
   input  logic          any_hit,
   input  logic [DW-1:0] first_d,
   output logic [DW-1:0] sel_d,
   output logic [DW-1:0] cur_d,
   output logic          aligned
);
   logic [DW-1:0] d_q;
   logic          al_q;
   logic          allow;

   assign allow   = realign_en || !al_q;
   assign sel_d   = (tick && allow && any_hit) ? first_d : d_q;
   assign cur_d   = d_q;
   assign aligned = al_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         d_q  <= '0;
         al_q <= 1'b0;
      end else if (tick) begin
         d_q  <= sel_d;
         al_q <= al_q | hit[sel_d];
      end
   end
endmodule

// File: rtl/comma_deser.sv
module comma_deser
   import comma_deser_pkg::*;
#(
   parameter int unsigned W  = DEF_WORD_W,
   parameter int unsigned CW = DEF_COMMA_W,
   parameter logic [CW-1:0] PAT_P = DEF_PAT_P,
   parameter logic [CW-1:0] PAT_N = DEF_PAT_N
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         bit_en,
   input  logic         bit_in,
   input  logic         realign_en,
   output logic [W-1:0] word_out,
   output logic         word_vld,
   output logic         comma_flag
);
   localparam int unsigned H  = 2*W-1;
   localparam int unsigned HM = W+CW-1;
   localparam int unsigned DW = $clog2(W);

   if (W < 2 || CW < 2 || CW > W) begin : g_bad_width
      $error("comma_deser: need 2 <= CW <= W");
   end
   if (PAT_P == PAT_N) begin : g_bad_pat
      $error("comma_deser: comma patterns must differ");
   end

   logic [H-1:0]  hist_nxt;
   logic          tick;
   logic [W-1:0]  hit;
   logic          any_hit;
   logic [DW-1:0] first_d;
   logic [DW-1:0] sel_d;
   logic [DW-1:0] cur_d;
   logic          aligned;
   logic [W-1:0]  win [W];

   cd_shift #(.W(W)) u_shift (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
      .hist_nxt(hist_nxt), .tick(tick)
   );

   cd_match #(.W(W), .CW(CW), .PAT_P(PAT_P), .PAT_N(PAT_N)) u_match (
      .hist(hist_nxt[HM-1:0]), .hit(hit), .any_hit(any_hit), .first_d(first_d)
   );

   cd_align #(.W(W)) u_align (
      .clk(clk), .rst_n(rst_n), .tick(tick), .realign_en(realign_en),
      .hit(hit), .any_hit(any_hit), .first_d(first_d),
      .sel_d(sel_d), .cur_d(cur_d), .aligned(aligned)
   );

   for (genvar d = 0; d < W; d++) begin : g_win
      assign win[d] = hist_nxt[W-1-d +: W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_out   <= '0;
         word_vld   <= 1'b0;
         comma_flag <= 1'b0;
      end else begin
         word_vld <= tick;
         if (tick) begin
            word_out   <= win[sel_d];
            comma_flag <= hit[sel_d];
         end
      end
   end
endmodule

// File: rtl/cd_chk.sv
module cd_chk #(
   parameter int unsigned W  = 10,
   parameter int unsigned CW = 7,
   parameter logic [CW-1:0] PAT_P = '0,
   parameter logic [CW-1:0] PAT_N = '0,
   localparam int unsigned DW = $clog2(W),
   localparam int unsigned BW = $clog2(W+1)+1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bit_en,
   input logic          realign_en,
   input logic [W-1:0]  word_out,
   input logic          word_vld,
   input logic          comma_flag,
   input logic [DW-1:0] cur_d,
   input logic          aligned
);
   logic [BW-1:0] bits_since;
   logic          out_is_comma;

   assign out_is_comma = (word_out[CW-1:0] == PAT_P) || (word_out[CW-1:0] == PAT_N);

   always_ff @(posedge clk) begin
      if (!rst_n) bits_since <= '0;
      else if (word_vld) bits_since <= bit_en ? BW'(1) : '0;
      else if (bit_en && bits_since != '1) bits_since <= bits_since + 1'b1;
   end

   AST_WORD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld |-> bits_since == BW'(W)); // R2
   AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld |=> !word_vld); // R2
   AST_FLAG_ON_COMMA: assert property (@(posedge clk) disable iff (!rst_n)
      comma_flag |-> out_is_comma); // R6
   AST_COMMA_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      out_is_comma |-> comma_flag); // R6
   AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !word_vld |-> $stable(word_out)); // R6
   AST_FROZEN_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      (aligned && !realign_en) |=> $stable(cur_d)); // R7
   AST_ALIGNED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      aligned |=> aligned); // R9
endmodule

bind comma_deser cd_chk #(.W(W), .CW(CW), .PAT_P(PAT_P), .PAT_N(PAT_N)) u_chk (
   .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .realign_en(realign_en),
   .word_out(word_out), .word_vld(word_vld), .comma_flag(comma_flag),
   .cur_d(cur_d), .aligned(aligned)
);

// File: tb/comma_deser_bench.sv
module comma_deser_bench;
   localparam int W = 10;
   localparam logic [9:0] K_P = 10'b0101111100;
   localparam logic [9:0] K_N = 10'b1010000011;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_en = 1'b0;
   logic bit_in = 1'b0;
   logic realign_en = 1'b1;
   logic [W-1:0] word_out;
   logic word_vld;
   logic comma_flag;

   comma_deser u_comma_deser (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
      .realign_en(realign_en), .word_out(word_out), .word_vld(word_vld),
      .comma_flag(comma_flag)
   );

   always #2 clk = ~clk;

   bit sb [0:8191];
   bit mb [0:8191];
   int L, k, dm, bits_seen;
   bit alm, lastb;
   string ptag;
   int n_tests, n_fail;
   int n_r4, n_r7, n_r8, n_r9, n_pos, n_neg;

   task automatic check(bit ok, string req, string what, logic [31:0] got, logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
      end
   endtask

   function automatic bit sbit(int i);
      return (i < 0) ? 1'b0 : sb[i];
   endfunction

   function automatic logic [9:0] win_at(int t, int d);
      logic [9:0] w;
      for (int j = 0; j < W; j++) w[j] = sbit(t - W - d + j);
      return w;
   endfunction

   function automatic bit is_c(logic [9:0] w);
      return (w[6:0] == 7'b1111100) || (w[6:0] == 7'b0000011);
   endfunction

   always @(posedge clk) if (rst_n && bit_en) bits_seen++;

   always @(negedge clk) begin : mon
      int t, fd;
      bit fnd, allow, ef;
      logic [9:0] ew;
      if (rst_n && word_vld) begin
         check(bits_seen == W, "R2", "bits between words", bits_seen, W);
         bits_seen = 0;
         k++;
         t = k * W;
         fnd = 0; fd = 0;
         for (int d = 0; d < W; d++)
            if (!fnd && is_c(win_at(t, d))) begin fnd = 1; fd = d; end
         allow = mb[t-1] || !alm;
         if (fnd && allow && fd != dm) begin
            if (mb[t-1]) n_r4++; else n_r8++;
         end
         if (fnd && !allow && fd != dm) begin
            if (ptag == "R9") n_r9++; else n_r7++;
         end
         if (fnd && allow) dm = fd;
         ew = win_at(t, dm);
         ef = is_c(ew);
         alm = alm | ef;
         check(word_out == ew, ptag, "word", word_out, ew);
         check(comma_flag == ef, "R6", "comma flag", comma_flag, ef);
         if (comma_flag && word_out[6:0] == 7'b1111100) n_pos++;
         if (comma_flag && word_out[6:0] == 7'b0000011) n_neg++;
      end
   end

   task automatic push_bit(bit b);
      sb[L] = b; mb[L] = realign_en; L++;
      lastb = b;
      bit_in = b; bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
      repeat ($urandom_range(0, 2)) @(negedge clk);
   endtask

   task automatic push_word(logic [9:0] w);
      for (int j = 0; j < W; j++) push_bit(w[j]);
   endtask

   task automatic push_data(int n);
      logic [9:0] w;
      for (int i = 0; i < n; i++) begin
         for (int p = 0; p < 5; p++) begin
            w[2*p]   = 1'($urandom_range(0, 1));
            w[2*p+1] = ~w[2*p];
         end
         push_word(w);
      end
   endtask

   task automatic push_junk(int n);
      for (int i = 0; i < n; i++) push_bit(~lastb);
   endtask

   task automatic do_reset(bit mode);
      @(negedge clk);
      rst_n = 1'b0; bit_en = 1'b0; realign_en = mode;
      repeat (3) @(negedge clk);
      check(word_out == '0, "R3", "word in reset", word_out, 0);
      check(word_vld == 1'b0, "R3", "valid in reset", word_vld, 0);
      check(comma_flag == 1'b0, "R3", "flag in reset", comma_flag, 0);
      L = 0; k = 0; dm = 0; alm = 0; lastb = 0; bits_seen = 0;
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin : stim
      n_tests = 0; n_fail = 0;
      n_r4 = 0; n_r7 = 0; n_r8 = 0; n_r9 = 0; n_pos = 0; n_neg = 0;
      ptag = "R1";

      // R1: plain words, no comma, boundary at reset position
      do_reset(1'b1);
      ptag = "R1";
      push_data(12);
      repeat (4) @(negedge clk);

      // R4: continuous realignment at every starting offset
      for (int off = 0; off < W; off++) begin
         do_reset(1'b1);
         ptag = "R4";
         push_junk(off);
         push_data(2);
         push_word(off[0] ? K_N : K_P);
         push_data(3);
         push_junk(1 + off % 9);
         push_word(off[0] ? K_P : K_N);
         push_data(3);
         repeat (4) @(negedge clk);
      end

      // R8 then R7: first comma only, later off-boundary comma ignored
      for (int off = 0; off < W; off++) begin
         do_reset(1'b0);
         ptag = "R8";
         push_junk(off);
         push_data(2);
         push_word(off[0] ? K_P : K_N);
         push_data(2);
         ptag = "R7";
         push_junk(1 + off % 9);
         push_word(K_P);
         push_data(2);
         push_junk(W - 1 - off % 9);
         push_word(K_N);
         push_data(3);
         repeat (4) @(negedge clk);
      end

      // R9: alignment gained while enabled, then mode dropped
      for (int off = 0; off < 5; off++) begin
         do_reset(1'b1);
         ptag = "R9";
         push_junk(off + 2);
         push_data(1);
         push_word(K_P);
         push_data(2);
         realign_en = 1'b0;
         push_junk(3 + off);
         push_word(K_N);
         push_data(3);
         repeat (4) @(negedge clk);
      end

      check(n_r4 > 0, "R4", "realignments seen", n_r4, 1);
      check(n_r8 > 0, "R8", "first-comma alignments seen", n_r8, 1);
      check(n_r7 > 0, "R7", "ignored commas seen", n_r7, 1);
      check(n_r9 > 0, "R9", "ignored commas after mode drop", n_r9, 1);
      check(n_pos > 0, "R5", "flagged 0011111 commas", n_pos, 1);
      check(n_neg > 0, "R5", "flagged 1100000 commas", n_neg, 1);
      finish_run();
   end
endmodule